// File: doc/BRIEF.md
# Shadow ROM Region Attribute Controller

This block is the memory-attribute part of a PC-style system controller. Software reaches five configuration registers through an I/O port pair. It first writes an index to one port, then reads or writes the selected register through the other port. From those registers the block decides, for every 16 KB segment between C0000 and EFFFF and for the BIOS area F0000 to FFFFF, where a memory read is served from and where a memory write goes.

The memory side is purely combinational. The block takes the current 20-bit memory address and returns a read-source code and a write-destination code in the same cycle. It also drives a flag that is set whenever some shadowed segment lies at D0000 or above. A separate control bit, taken from one register write, tells the system to reset when the processor halts. The DRAM controller and the bus cycle timing belong to other blocks.

Top module: `shadow_attr_ctl`

## Requirements
- R1: A write to I/O port 0x22 loads the 8-bit index. A read of port 0x24 returns the register that the index selects. A read of any other port, including 0x22, returns 0xFF.
- R2: A data-port write is stored only when the index is 0x10 to 0x14. Any other index reads back 0x00 and does not change the memory attributes.
- R3: After synchronous reset, register 0x10 holds 0x3F, register 0x11 holds 0xF0, registers 0x12 to 0x14 hold 0x00, and `halt_reset` is 0.
- R4: A data-port write with index 0x14 copies bit 6 of the written value onto `halt_reset` from the next cycle. `halt_reset` changes at no other time.
- R5: Read codes are 0 pass-through, 1 internal RAM, 2 external bus, 3 external any-source. Write codes are 0 pass-through, 1 internal RAM, 2 external bus, 3 discard. When register 0x11 bit 7 is set, every address from F0000 to FFFFF reads with code 3 and writes with code 1.
- R6: When register 0x11 bit 7 is clear, F0000 to F0FFF reads internal RAM. Writes there go to internal RAM if register 0x14 bit 7 is set and are discarded if it is clear.
- R7: When register 0x11 bit 7 is clear, F1000 to FFFFF reads internal RAM and discards writes.
- R8: Segment i (0 to 11) covers C0000 + i*16 KB. Its enable is register 0x13 bit i+4 for i < 4, and register 0x12 bit i-4 for i >= 4.
- R9: A segment is shadowed only when its enable bit is set and the qualifier bit 4+g of register 0x11 is also set, where g = i/4 is the 64 KB group.
- R10: A shadowed segment reads internal RAM. If register 0x11 bit g is clear, its writes are discarded. If the bit is set, writes go to internal RAM when register 0x11 bit 3 is set and to the external bus when it is clear.
- R11: A non-shadowed segment discards writes. It reads with code 3 from E0000 upward and with code 2 in C0000 to DFFFF.
- R12: `high_shadow` is 1 exactly when at least one of segments 4 to 11 (D0000 to EFFFF) is shadowed. It does not depend on the current address.
- R13: Addresses below C0000 give pass-through read and write codes. A register change shows on the memory outputs in the cycle after the data-port write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr | input | 20 | Current memory address |
| rd_src | output | 2 | Read source code for mem_addr |
| wr_dst | output | 2 | Write destination code for mem_addr |
| high_shadow | output | 1 | Some segment at D0000 or above is shadowed |
| halt_reset | output | 1 | Reset-on-halt control |

## Verification
The bench checks the scattered enable mapping at segment 0 and at segment 4. If a design took both enables from one register, or got the bit offset wrong, the wrong segment would turn to internal RAM. It clears one group qualifier while that group's enable stays set. A design that ignores the qualifier would keep reading D0000 from internal RAM and would keep `high_shadow` raised. It also checks the split at F1000 against register 0x14 bit 7, and the external-bus write path when bit 3 is clear. A design that shares one rule across the whole BIOS area, or that treats write mode as always internal, gives the wrong write code at those addresses.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int SEG_COUNT     = 12;
    localparam int SEG_PER_GROUP = 4;
    localparam int GROUP_COUNT   = SEG_COUNT / SEG_PER_GROUP;
    localparam int SEG_IDX_W     = $clog2(SEG_COUNT);
    localparam int ANY_FROM_SEG  = 8;   // E0000 and up
    localparam int HIGH_FROM_SEG = 4;   // D0000 and up
    localparam int REG_COUNT     = 5;
    localparam logic [7:0] REG_BASE = 8'h10;

    typedef enum logic [1:0] {
        RD_PASS   = 2'd0,
        RD_INT    = 2'd1,
        RD_EXT    = 2'd2,
        RD_EXTANY = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        WR_PASS = 2'd0,
        WR_INT  = 2'd1,
        WR_EXT  = 2'd2,
        WR_DROP = 2'd3
    } wr_dst_e;

    typedef struct packed {
        rd_src_e rd;
        wr_dst_e wr;
    } attr_t;

    typedef struct packed {
        logic [7:0] general;   // 0x10
        logic [7:0] area_ctl;  // 0x11
        logic [7:0] seg_hi;    // 0x12
        logic [7:0] seg_lo;    // 0x13
        logic [7:0] bios_ctl;  // 0x14
    } cfg_t;

    function automatic logic [7:0] reg_reset_val(input int k);
        case (k)
            0:       return 8'h3F;
            1:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic attr_t seg_rule(input logic shadowed, input logic wmode,
                                       input logic copy, input logic any_area);
        attr_t a;
        if (shadowed) begin
            a.rd = RD_INT;
            if (!wmode)    a.wr = WR_DROP;
            else if (copy) a.wr = WR_INT;
            else           a.wr = WR_EXT;
        end else begin
            a.rd = any_area ? RD_EXTANY : RD_EXT;
            a.wr = WR_DROP;
        end
        return a;
    endfunction

    localparam attr_t ATTR_PASS = '{rd: RD_PASS, wr: WR_PASS};

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import shadow_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output cfg_t             cfg,
    output logic             halt_reset
);
    localparam logic [7:0] HALT_IDX = REG_BASE + 8'(REG_COUNT - 1);

    logic [7:0] index_q;
    logic [7:0] regs_q [REG_COUNT];
    logic       idx_hit;
    logic [7:0] idx_off;
    logic       hit_idx_port;
    logic       hit_data_port;

    assign hit_idx_port  = (io_addr == IDX_PORT[IO_AW-1:0]);
    assign hit_data_port = (io_addr == DATA_PORT[IO_AW-1:0]);
    assign idx_off       = index_q - REG_BASE;
    assign idx_hit       = (index_q >= REG_BASE) && (idx_off < 8'(REG_COUNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= 8'h00;
        end else if (io_wr && hit_idx_port) begin
            index_q <= io_wdata;
        end
    end

    for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[k] <= reg_reset_val(k);
            end else if (io_wr && hit_data_port && idx_hit && (idx_off == 8'(k))) begin
                regs_q[k] <= io_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_reset <= 1'b0;
        end else if (io_wr && hit_data_port && (index_q == HALT_IDX)) begin
            halt_reset <= io_wdata[6];
        end
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && hit_data_port) begin
            io_rdata = 8'h00;
            for (int k = 0; k < REG_COUNT; k++) begin
                if (idx_hit && (idx_off == 8'(k))) io_rdata = regs_q[k];
            end
        end
    end

    assign cfg.general  = regs_q[0];
    assign cfg.area_ctl = regs_q[1];
    assign cfg.seg_hi   = regs_q[2];
    assign cfg.seg_lo   = regs_q[3];
    assign cfg.bios_ctl = regs_q[4];

endmodule

// File: rtl/seg_plane.sv
module seg_plane
    import shadow_pkg::*;
(
    input  cfg_t                  cfg,
    output attr_t [SEG_COUNT-1:0] seg_attr,
    output logic  [SEG_COUNT-1:0] seg_shadow
);
    logic [SEG_COUNT-1:0] seg_en;

    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
        localparam int GRP = i / SEG_PER_GROUP;
        if (i < SEG_PER_GROUP) begin : g_lo
            assign seg_en[i] = cfg.seg_lo[i + 4];
        end else begin : g_hi
            assign seg_en[i] = cfg.seg_hi[i - SEG_PER_GROUP];
        end
        assign seg_shadow[i] = seg_en[i] & cfg.area_ctl[GRP + 4];
        assign seg_attr[i]   = seg_rule(seg_shadow[i], cfg.area_ctl[GRP],
                                        cfg.area_ctl[3], (i >= ANY_FROM_SEG));
    end

endmodule

// File: rtl/bios_plane.sv
module bios_plane
    import shadow_pkg::*;
(
    input  cfg_t        cfg,
    input  logic [15:0] offset,
    output attr_t       bios_attr
);
    logic low_page;

    assign low_page = (offset[15:12] == 4'h0);

    always_comb begin
        if (cfg.area_ctl[7]) begin
            bios_attr.rd = RD_EXTANY;
            bios_attr.wr = WR_INT;
        end else begin
            bios_attr.rd = RD_INT;
            if (low_page && cfg.bios_ctl[7]) bios_attr.wr = WR_INT;
            else                             bios_attr.wr = WR_DROP;
        end
    end

endmodule

// File: rtl/shadow_attr_ctl.sv
module shadow_attr_ctl
    import shadow_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [19:0]      mem_addr,
    output logic [1:0]       rd_src,
    output logic [1:0]       wr_dst,
    output logic             high_shadow,
    output logic             halt_reset
);
    cfg_t                  cfg;
    attr_t [SEG_COUNT-1:0] seg_attr;
    logic  [SEG_COUNT-1:0] seg_shadow;
    attr_t                 bios_attr;
    attr_t                 sel_attr;
    logic                  in_seg_area;
    logic                  in_bios_area;
    logic [SEG_IDX_W-1:0]  seg_idx;

    cfg_regs #(
        .IO_AW     (IO_AW),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cfg        (cfg),
        .halt_reset (halt_reset)
    );

    seg_plane u_seg (
        .cfg        (cfg),
        .seg_attr   (seg_attr),
        .seg_shadow (seg_shadow)
    );

    bios_plane u_bios (
        .cfg       (cfg),
        .offset    (mem_addr[15:0]),
        .bios_attr (bios_attr)
    );

    // C/D/E pages map to segment index = address bits 17:14
    assign in_seg_area  = (mem_addr[19:18] == 2'b11) && (mem_addr[17:16] != 2'b11);
    assign in_bios_area = (mem_addr[19:16] == 4'hF);
    assign seg_idx      = mem_addr[17:14];

    always_comb begin
        if (in_bios_area)     sel_attr = bios_attr;
        else if (in_seg_area) sel_attr = seg_attr[seg_idx];
        else                  sel_attr = ATTR_PASS;
    end

    assign rd_src      = sel_attr.rd;
    assign wr_dst      = sel_attr.wr;
    assign high_shadow = |seg_shadow[SEG_COUNT-1:HIGH_FROM_SEG];

endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk
    import shadow_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024
) (
    input logic             clk,
    input logic             rst,
    input logic             io_wr,
    input logic             io_rd,
    input logic [IO_AW-1:0] io_addr,
    input logic [7:0]       io_wdata,
    input logic [7:0]       io_rdata,
    input logic [19:0]      mem_addr,
    input logic [1:0]       rd_src,
    input logic [1:0]       wr_dst,
    input logic             high_shadow,
    input logic             halt_reset
);
    logic [7:0] mirror_idx;

    always_ff @(posedge clk) begin
        if (rst)                                              mirror_idx <= 8'h00;
        else if (io_wr && io_addr == IDX_PORT[IO_AW-1:0])     mirror_idx <= io_wdata;
    end

    logic halt_write;
    assign halt_write = io_wr && (io_addr == DATA_PORT[IO_AW-1:0]) && (mirror_idx == 8'h14);

    // R1
    other_port_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr != DATA_PORT[IO_AW-1:0]) |-> io_rdata == 8'hFF);

    // R4
    halt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        halt_write |=> halt_reset == $past(io_wdata[6]));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !halt_write |=> $stable(halt_reset));

    // R7
    bios_upper_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[19:16] == 4'hF && mem_addr[15:12] != 4'h0 && rd_src == 2'd1)
            |-> wr_dst == 2'd3);

    // R11
    unshadowed_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 20'hC0000 && mem_addr < 20'hF0000 && rd_src != 2'd1)
            |-> wr_dst == 2'd3);

    // R12
    high_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 20'hD0000 && mem_addr < 20'hF0000 && rd_src == 2'd1)
            |-> high_shadow);

    // R13
    low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr < 20'hC0000) |-> (rd_src == 2'd0 && wr_dst == 2'd0));

endmodule

bind shadow_attr_ctl shadow_attr_chk #(
    .IO_AW     (IO_AW),
    .IDX_PORT  (IDX_PORT),
    .DATA_PORT (DATA_PORT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .mem_addr    (mem_addr),
    .rd_src      (rd_src),
    .wr_dst      (wr_dst),
    .high_shadow (high_shadow),
    .halt_reset  (halt_reset)
);

// File: tb/sim_shadow_attr_ctl.sv
`timescale 1ns/1ps
module sim_shadow_attr_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = 20'h00000;
    logic [1:0]  rd_src;
    logic [1:0]  wr_dst;
    logic        high_shadow;
    logic        halt_reset;

    always #2.5 clk = ~clk;

    shadow_attr_ctl u0 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .rd_src(rd_src), .wr_dst(wr_dst), .high_shadow(high_shadow),
        .halt_reset(halt_reset)
    );

    // read codes: 0 pass, 1 int, 2 ext, 3 ext-any; write codes: 0 pass, 1 int, 2 ext, 3 drop
    localparam int R_PASS = 0, R_INT = 1, R_EXT = 2, R_ANY = 3;
    localparam int W_PASS = 0, W_INT = 1, W_EXT = 2, W_DROP = 3;

    typedef struct {
        int    kind;   // 0 mem attributes, 1 io read data, 2 halt_reset
        int    expv;
        string req;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            case (it.kind)
                0:       act = {27'd0, rd_src, wr_dst, high_shadow};
                1:       act = {24'd0, io_rdata};
                default: act = {31'd0, halt_reset};
            endcase
            compared++;
            if (act != it.expv) begin
                mismatched++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.expv);
            end
        end
    end

    task automatic push(input int kind, input int expv, input string req);
        item_t it;
        it.kind = kind; it.expv = expv; it.req = req;
        q.push_back(it);
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        io_write(16'h0022, idx);
        io_write(16'h0024, val);
    endtask

    task automatic expect_port(input logic [15:0] a, input int expv, input string req);
        @(posedge clk); #1;
        io_rd = 1'b1; io_addr = a;
        push(1, expv, req);
        @(negedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] idx, input int expv, input string req);
        io_write(16'h0022, idx);
        expect_port(16'h0024, expv, req);
    endtask

    task automatic expect_mem(input logic [19:0] a, input int rd, input int wr,
                              input int hs, input string req);
        @(posedge clk); #1;
        mem_addr = a;
        push(0, rd * 8 + wr * 2 + hs, req);
        @(negedge clk); #1;
    endtask

    task automatic expect_halt(input int expv, input string req);
        @(posedge clk); #1;
        push(2, expv, req);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        expect_halt(0, "R3 halt_reset after reset");
        expect_reg(8'h10, 8'h3F, "R3 reg 0x10 reset");
        expect_reg(8'h11, 8'hF0, "R3 reg 0x11 reset");
        expect_reg(8'h12, 8'h00, "R3 reg 0x12 reset");
        expect_mem(20'hF8000, R_ANY, W_INT, 0, "R5 BIOS external-read mode");
        expect_mem(20'hC0000, R_EXT, W_DROP, 0, "R11 C0000 not shadowed");
        expect_mem(20'hE0000, R_ANY, W_DROP, 0, "R11 E0000 not shadowed");
        expect_mem(20'h80000, R_PASS, W_PASS, 0, "R13 low address pass");

        // port decode
        expect_port(16'h0022, 8'hFF, "R1 index port read");
        expect_port(16'h0030, 8'hFF, "R1 undecoded port read");

        // write filter
        set_reg(8'h20, 8'h55);
        expect_reg(8'h20, 8'h00, "R2 index 0x20 not stored");
        expect_mem(20'hC0000, R_EXT, W_DROP, 0, "R2 attributes unchanged");
        set_reg(8'h10, 8'hA5);
        expect_reg(8'h10, 8'hA5, "R2 index 0x10 stored");

        // reset-on-halt
        set_reg(8'h14, 8'h40);
        expect_halt(1, "R4 halt_reset set");

        // BIOS area with bit 7 clear
        set_reg(8'h11, 8'h70);
        expect_mem(20'hF0800, R_INT, W_DROP, 0, "R6 low page write-protected");
        expect_mem(20'hF2000, R_INT, W_DROP, 0, "R7 upper BIOS");
        set_reg(8'h14, 8'hC0);
        expect_mem(20'hF0800, R_INT, W_INT, 0, "R6 low page writable");
        expect_mem(20'hF1000, R_INT, W_DROP, 0, "R7 F1000 boundary");
        expect_mem(20'hF0FFF, R_INT, W_INT, 0, "R6 F0FFF boundary");
        expect_halt(1, "R4 halt_reset still set");
        set_reg(8'h14, 8'h00);
        expect_halt(0, "R4 halt_reset cleared");

        // segments
        set_reg(8'h13, 8'h10);
        expect_mem(20'hC0000, R_INT, W_DROP, 0, "R8 seg0 enable from reg 0x13 bit4");
        expect_mem(20'hC4000, R_EXT, W_DROP, 0, "R8 seg1 not enabled");
        set_reg(8'h11, 8'h71);
        expect_mem(20'hC3FFF, R_INT, W_EXT, 0, "R10 write mode external");
        set_reg(8'h11, 8'h79);
        expect_mem(20'hC0000, R_INT, W_INT, 0, "R10 write mode internal copy");
        set_reg(8'h12, 8'h01);
        expect_mem(20'hD0000, R_INT, W_DROP, 1, "R12 seg4 shadowed high flag");
        expect_mem(20'hD4000, R_EXT, W_DROP, 1, "R8 seg5 not enabled");
        set_reg(8'h11, 8'h59);
        expect_mem(20'hD0000, R_EXT, W_DROP, 0, "R9 group qualifier cleared");
        expect_mem(20'hC0000, R_INT, W_INT, 0, "R9 group 0 still qualified");
        set_reg(8'h12, 8'h80);
        expect_mem(20'hEC000, R_INT, W_DROP, 1, "R10 seg11 read-only");
        expect_mem(20'hE8000, R_ANY, W_DROP, 1, "R11 seg10 ext-any");
        expect_mem(20'hBFFFC, R_PASS, W_PASS, 1, "R13 below C0000 pass");
        expect_reg(8'h13, 8'h10, "R1 readback reg 0x13");

        repeat (2) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule